// File: doc/BRIEF.md
# Frame-Synchronous Byte Scrambler

This block whitens a byte-wide frame stream before it goes onto a line. It has a seven-stage pseudo-random generator. The generator is advanced eight bit-steps on each accepted byte, and the byte is XORed with the eight bits produced. At every frame start the generator is reloaded to all ones, so transmitter and receiver stay locked without any exchange of state. The first nine bytes of each frame carry alignment overhead. These bytes leave the block untouched, and the generator does not move while they pass.

XOR with a keystream undoes itself. An identical instance placed at the receive side, given the same frame-start marking, therefore returns the original bytes. The output is registered, and each byte leaves exactly one clock after it is accepted.

Top module: `frame_byte_scrambler`

## Requirements
- R1: While reset is held and on the first cycle after it, `data_o` is 0x00 and `valid_o` is 0. After reset, before any frame start, scrambling is already active from the all-ones generator state, so a first valid 0x00 byte leaves as 0xFE.
- R2: `valid_o` equals the `valid_i` of the previous clock. A byte accepted with `valid_i=1` appears on `data_o` on the next clock.
- R3: A byte presented with `valid_i=1` and `sof_i=1` is byte 0 of a new frame. It reloads the generator to all ones (0x7F).
- R4: Bytes 0 through 8 of a frame leave equal to their input.
- R5: The generator does not advance during bytes 0 to 8. Byte 9 is XORed with mask 0xFE and byte 10 with mask 0x04.
- R6: The generator steps as follows: the output bit is stage 7 (the MSB), and the new stage 1 is the XOR of stages 7 and 6, which is x^7+x^6+1. It takes eight steps per byte. The first bit produced goes to data bit 7, and the last goes to bit 0. The generator state is never all zeros.
- R7: On a clock with `valid_i=0`, `data_o`, the generator state and the byte position all hold.
- R8: A frame start arriving part-way through a frame restarts the count at byte 0. Nine more bytes are then bypassed, and the following byte gets mask 0xFE.
- R9: A second instance fed with `data_o`/`valid_o`, and with `sof_i` delayed by one clock, reproduces the original bytes.
- R10: `sof_i=1` with `valid_i=0` has no effect. The byte sequence and generator continue as if it were absent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Input byte strobe |
| sof_i | input | 1 | Marks the current valid byte as byte 0 of a frame |
| data_i | input | 8 | Input byte |
| valid_o | output | 1 | Output byte strobe, one clock after `valid_i` |
| data_o | output | 8 | Scrambled or bypassed byte |

## Verification
The bench feeds the block several kinds of input, and each one reveals a different fault:
- Zero bytes expose the raw keystream, so a wrong tap, bit order or reload value shows as a mismatch against 0xFE, 0x04 and the later masks.
- All-ones bytes and alternating patterns (0xAA, 0x55) expose faults that only show on the data path, such as an inverted XOR or a bypass that also applies the mask.
- Gaps in `valid_i` inside the overhead window and inside the payload separate a generator that holds from one that advances on idle clocks.
- A restart in mid-frame and a frame-start flag without a valid byte separate correct frame tracking from a counter that keys on the raw flag.
- A chained second instance confirms that the transform undoes itself.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    parameter int unsigned FBS_DATA_W = 8;
    parameter int unsigned FBS_LFSR_W = 7;
    parameter int unsigned FBS_TAP_HI = 6;
    parameter int unsigned FBS_TAP_LO = 5;
    parameter int unsigned FBS_BYPASS = 9;
endpackage

// File: rtl/fbs_mask_gen.sv
module fbs_mask_gen
    import fbs_pkg::*;
#(
    parameter int unsigned DATA_W = FBS_DATA_W,
    parameter int unsigned LFSR_W = FBS_LFSR_W,
    parameter int unsigned TAP_HI = FBS_TAP_HI,
    parameter int unsigned TAP_LO = FBS_TAP_LO
) (
    input  logic [LFSR_W-1:0] seed_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [LFSR_W-1:0] seed_next_o
);
    // Unrolled serial generator: DATA_W steps per byte, first bit to MSB.
    logic [LFSR_W-1:0] walk;

    always_comb begin
        walk = seed_i;
        for (int k = 0; k < int'(DATA_W); k++) begin
            mask_o[DATA_W-1-k] = walk[LFSR_W-1];
            walk = {walk[LFSR_W-2:0], walk[TAP_HI] ^ walk[TAP_LO]};
        end
        seed_next_o = walk;
    end

    // R6: a non-zero state never collapses to the all-zero lock-up state
    always_comb begin
        if (seed_i != '0) begin
            p_nonzero_keep_r6: assert (seed_next_o != '0);
        end
    end
endmodule

// File: rtl/fbs_frame_pos.sv
module fbs_frame_pos
    import fbs_pkg::*;
#(
    parameter int unsigned BYPASS_BYTES = FBS_BYPASS
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic valid_i,
    input  logic sof_i,
    output logic start_o,
    output logic bypass_o
);
    localparam int unsigned POS_W = $clog2(BYPASS_BYTES + 1);
    localparam logic [POS_W-1:0] POS_LIMIT = POS_W'(BYPASS_BYTES);

    logic [POS_W-1:0] pos_d, pos_q;
    logic [POS_W-1:0] eff_pos;

    always_comb begin
        start_o  = valid_i & sof_i;
        eff_pos  = start_o ? '0 : pos_q;
        bypass_o = (eff_pos < POS_LIMIT);
        pos_d    = pos_q;
        if (valid_i && bypass_o) begin
            pos_d = eff_pos + POS_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pos_q <= POS_LIMIT;
        end else begin
            pos_q <= pos_d;
        end
    end

    // R4: position never runs past the end of the overhead window
    p_pos_bound_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        pos_q <= POS_LIMIT);

    // R3: a frame-start byte is counted as byte 0
    p_sof_first_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && sof_i) |=> (pos_q == POS_W'(1)));

    // R10: a frame-start flag without a valid byte leaves the position alone
    p_sof_ignored_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (!valid_i && sof_i) |=> $stable(pos_q));
endmodule

// File: rtl/frame_byte_scrambler.sv
module frame_byte_scrambler
    import fbs_pkg::*;
#(
    parameter int unsigned DATA_W       = FBS_DATA_W,
    parameter int unsigned LFSR_W       = FBS_LFSR_W,
    parameter int unsigned TAP_HI       = FBS_TAP_HI,
    parameter int unsigned TAP_LO       = FBS_TAP_LO,
    parameter int unsigned BYPASS_BYTES = FBS_BYPASS
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              valid_i,
    input  logic              sof_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    localparam logic [LFSR_W-1:0] SEED_ONES = {LFSR_W{1'b1}};

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [DATA_W-1:0] data;
        logic              valid;
    } scr_state_t;

    scr_state_t        st_d, st_q;
    logic              frame_start;
    logic              in_bypass;
    logic [LFSR_W-1:0] gen_seed;
    logic [DATA_W-1:0] gen_mask;
    logic [LFSR_W-1:0] gen_next;

    fbs_frame_pos #(
        .BYPASS_BYTES(BYPASS_BYTES)
    ) pos_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .valid_i (valid_i),
        .sof_i   (sof_i),
        .start_o (frame_start),
        .bypass_o(in_bypass)
    );

    assign gen_seed = frame_start ? SEED_ONES : st_q.lfsr;

    fbs_mask_gen #(
        .DATA_W(DATA_W),
        .LFSR_W(LFSR_W),
        .TAP_HI(TAP_HI),
        .TAP_LO(TAP_LO)
    ) gen_i (
        .seed_i     (gen_seed),
        .mask_o     (gen_mask),
        .seed_next_o(gen_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_i;
        if (valid_i) begin
            if (in_bypass) begin
                st_d.data = data_i;
                st_d.lfsr = gen_seed;
            end else begin
                st_d.data = data_i ^ gen_mask;
                st_d.lfsr = gen_next;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.lfsr  <= SEED_ONES;
            st_q.data  <= '0;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign data_o  = st_q.data;

    // R2: output strobe follows input strobe by one clock
    p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i |=> valid_o);
    p_valid_drop_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |=> !valid_o);

    // R4: the frame-start byte leaves unchanged
    p_sof_pass_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && sof_i) |=> (data_o == $past(data_i)));

    // R5: after a bypassed byte the generator still holds all ones
    p_bypass_frozen_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && sof_i) |=> (st_q.lfsr == SEED_ONES));

    // R7: idle clocks hold output and generator
    p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |=> ($stable(st_q.lfsr) && $stable(data_o)));

    // R6: the generator never reaches the all-zero state
    p_never_zero_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.lfsr != '0);
endmodule

// File: tb/frame_byte_scrambler_tb_top.sv
module frame_byte_scrambler_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       valid_i, sof_i;
    logic [7:0] data_i;
    logic       valid_o;
    logic [7:0] data_o;
    logic       sof_q;
    logic       rx_valid;
    logic [7:0] rx_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    frame_byte_scrambler dut_i (
        .clk_i(clk), .rst_i(rst), .valid_i(valid_i), .sof_i(sof_i),
        .data_i(data_i), .valid_o(valid_o), .data_o(data_o)
    );

    // receive side: frame start delayed to line up with valid_o (R9)
    always @(posedge clk) sof_q <= rst ? 1'b0 : sof_i;

    frame_byte_scrambler rx_i (
        .clk_i(clk), .rst_i(rst), .valid_i(valid_o), .sof_i(sof_q),
        .data_i(data_o), .valid_o(rx_valid), .data_o(rx_data)
    );

    // stimulus table: {valid, sof, data}
    localparam int NVEC = 32;
    localparam logic [9:0] VEC [NVEC] = '{
        {2'b11, 8'h3C}, {2'b10, 8'hFF}, {2'b00, 8'h11}, {2'b10, 8'hAA},
        {2'b10, 8'h55}, {2'b10, 8'h00}, {2'b00, 8'h77}, {2'b10, 8'h81},
        {2'b10, 8'h7E}, {2'b10, 8'hC3}, {2'b10, 8'h5A}, {2'b10, 8'h00},
        {2'b10, 8'hFF}, {2'b00, 8'h99}, {2'b10, 8'hAA}, {2'b10, 8'h55},
        {2'b10, 8'h00}, {2'b10, 8'h12}, {2'b10, 8'h34}, {2'b10, 8'hFF},
        {2'b11, 8'hF6}, {2'b10, 8'hF6}, {2'b10, 8'hF6}, {2'b10, 8'h28},
        {2'b10, 8'h28}, {2'b10, 8'h28}, {2'b10, 8'h01}, {2'b10, 8'h00},
        {2'b10, 8'h00}, {2'b10, 8'hA5}, {2'b10, 8'h00}, {2'b10, 8'h0F}
    };

    // independent reference state
    logic [6:0] m_lfsr;
    int         m_pos;
    logic [7:0] m_out;
    logic       m_valid;
    logic       h1_v, h2_v;
    logic [7:0] h1_d, h2_d;

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_lfsr = 7'h7F; m_pos = 9; m_out = 8'h00; m_valid = 1'b0;
        h1_v = 1'b0; h2_v = 1'b0; h1_d = '0; h2_d = '0;
    endtask

    task automatic model_step(input logic v, input logic s, input logic [7:0] d,
                              output string tag);
        logic [7:0] mask;
        m_valid = v;
        tag = "R7";
        if (v) begin
            if (s) begin m_pos = 0; m_lfsr = 7'h7F; end
            if (m_pos < 9) begin
                m_out = d; m_pos++; tag = "R4";
            end else begin
                for (int b = 7; b >= 0; b--) begin
                    mask[b] = m_lfsr[6];
                    m_lfsr  = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
                end
                m_out = d ^ mask; tag = "R6";
            end
        end
    endtask

    // called at a negedge: drive, wait one clock, check
    task automatic step(input logic v, input logic s, input logic [7:0] d,
                        input string force_tag);
        string tag;
        valid_i = v; sof_i = s; data_i = d;
        model_step(v, s, d, tag);
        if (force_tag != "") tag = force_tag;
        h2_v = h1_v; h2_d = h1_d; h1_v = v; h1_d = d;
        @(negedge clk);
        check(valid_o == m_valid, "R2", {7'd0, valid_o}, {7'd0, m_valid});
        check(data_o == m_out, tag, data_o, m_out);
        if (h2_v) check(rx_valid && rx_data == h2_d, "R9", rx_data, h2_d);
    endtask

    task automatic do_reset();
        rst = 1'b1; valid_i = 1'b0; sof_i = 1'b0; data_i = 8'h00;
        repeat (3) @(negedge clk);
        check(data_o == 8'h00 && valid_o == 1'b0, "R1", data_o, 8'h00);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        check(data_o == 8'h00 && valid_o == 1'b0, "R1", data_o, 8'h00);
    endtask

    initial begin
        do_reset();
        // R1: scrambling live straight out of reset
        step(1'b1, 1'b0, 8'h00, "R1");
        check(data_o == 8'hFE, "R1", data_o, 8'hFE);
        step(1'b0, 1'b0, 8'h00, "R7");

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][9], VEC[i][8], VEC[i][7:0], "");
        end

        // R3/R5: new frame, zero payload exposes masks 0xFE then 0x04
        step(1'b1, 1'b1, 8'h00, "R3");
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 8'h00, "R4");
        step(1'b1, 1'b0, 8'h00, "R5");
        check(data_o == 8'hFE, "R5", data_o, 8'hFE);
        step(1'b1, 1'b0, 8'h00, "R5");
        check(data_o == 8'h04, "R5", data_o, 8'h04);

        // R10: frame-start flag without valid is ignored
        step(1'b0, 1'b1, 8'hEE, "R10");
        step(1'b1, 1'b0, 8'h00, "R10");
        step(1'b1, 1'b0, 8'hFF, "R10");

        // R8: restart inside the overhead window
        step(1'b1, 1'b1, 8'h10, "R8");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 8'h20, "R8");
        step(1'b1, 1'b1, 8'h30, "R8");
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 8'h40, "R8");
        step(1'b1, 1'b0, 8'h00, "R8");
        check(data_o == 8'hFE, "R8", data_o, 8'hFE);

        // R7: idle gap inside payload then resume
        step(1'b0, 1'b0, 8'h5A, "R7");
        step(1'b0, 1'b0, 8'hA5, "R7");
        step(1'b1, 1'b0, 8'h00, "R7");
        step(1'b0, 1'b0, 8'h00, "");
        step(1'b0, 1'b0, 8'h00, "");

        // R1: reset mid-stream returns to reset state
        do_reset();
        step(1'b1, 1'b0, 8'hFF, "R1");
        check(data_o == 8'h01, "R1", data_o, 8'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule